// File: doc/BRIEF.md
# Dual-Channel Signed Motor PWM Generator

This block drives two H-bridge motor channels from one shared timebase. Each channel takes a signed duty command. The block turns the command into a pulse-width output and a direction output. The period counter advances on every clock, with no prescaler. A period lasts 2^CNT_W clocks, which is 1024 with the default settings.

A command becomes a magnitude and a direction bit. A per-channel reverse input can flip the direction to suit how each motor is wired. Neither the magnitude nor the direction reaches the outputs at once. Both are captured at the end of each period, for both channels at the same time. As a result, a motor never sees a new direction paired with an old duty.

A one-cycle sync pulse marks the start of each period. A controller can use it to time its command updates.

Top module: `motor_pwm_pair`

## Requirements
- R1: The period counter counts 0 up to 2^CNT_W-1 (1023 by default), one step per clock, then returns to 0. `sync_o` is high for exactly one clock, in the first cycle (count 0) of every period that follows a wrap. It stays low in the first period after reset.
- R2: In each period, `pwm_o[k]` is high from count 0 while the count is below the channel's active magnitude, then low for the rest of the period. Over one period it is therefore high for exactly `magnitude` clocks.
- R3: A positive command C gives magnitude C and computed direction 1.
- R4: A negative command C gives magnitude -C and computed direction 0.
- R5: A zero command gives magnitude 0, so the PWM output stays low for the whole period. Its computed direction is 0.
- R6: Commands are 11-bit two's complement. The only magnitude above 1023, from command -1024, saturates to 1023.
- R7: `dir_o[k]` equals the computed direction XOR `rev_i[k]`. This includes the zero-command case.
- R8: `cmd_i` and `rev_i` are sampled only on the clock edge that ends a period, taken while the count is at its maximum. Changes at any other time leave `pwm_o` and `dir_o` untouched until that edge. Magnitude and direction switch on the same edge.
- R9: Both channels take their new values on the same edge, so neither channel lags the other by a period.
- R10: Synchronous active-high reset clears the counter, both magnitudes and both directions. While reset is held, and in the first period after it, both PWM outputs, both direction outputs and `sync_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counter rate |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | NUM_CH*11 | Signed commands; channel k at bits [11k+10:11k] |
| rev_i | input | NUM_CH | Per-channel direction inversion, bit k for channel k |
| pwm_o | output | NUM_CH | Pulse-width outputs, active high |
| dir_o | output | NUM_CH | Direction outputs |
| sync_o | output | 1 | One-clock pulse at the start of each period |

## Verification
The following are checked on every cycle:
- the counter stepping and its wrap;
- the sync pulse landing at count 0;
- direction and magnitude holding steady except across a period edge;
- a zero magnitude keeping the output low;
- the output rising at period start and falling exactly at the compare point.

The following only the bench's scenarios can show:
- the arithmetic from command to magnitude and direction, including saturation of -1024 and the reverse XOR;
- a command written in the last cycle still reaching the next period;
- both channels switching together.

The bench shows these by counting high cycles over whole periods.

// File: rtl/mpp_pkg.sv
package mpp_pkg;
    localparam int CNT_W  = 10;
    localparam int CMD_W  = 11;
    localparam int NUM_CH = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CMD_W:0]   SAT_LIM = (CMD_W+1)'(2**CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] mag;
        logic             dir;
    } drive_t;

    function automatic drive_t to_drive(input logic [CMD_W-1:0] cmd, input logic rev);
        drive_t d;
        logic [CMD_W:0] ext;
        logic [CMD_W:0] absv;
        ext  = {cmd[CMD_W-1], cmd};
        absv = cmd[CMD_W-1] ? (~ext + 1'b1) : ext;
        if (absv > SAT_LIM)
            d.mag = CNT_MAX;
        else
            d.mag = absv[CNT_W-1:0];
        d.dir = ((!cmd[CMD_W-1]) && (cmd != '0)) ^ rev;
        return d;
    endfunction
endpackage

// File: rtl/mpp_timebase.sv
module mpp_timebase
    import mpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o,
    output logic             sync_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             sync_q;

    assign last_o = (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            sync_q <= last_o;
        end
    end

    assign cnt_o  = cnt_q;
    assign sync_o = sync_q;
endmodule

// File: rtl/mpp_sm_convert.sv
module mpp_sm_convert
    import mpp_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             rev_i,
    output drive_t           drv_o
);
    always_comb drv_o = to_drive(cmd_i, rev_i);
endmodule

// File: rtl/mpp_channel.sv
module mpp_channel
    import mpp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  drive_t           next_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pwm_o,
    output logic             dir_o,
    output logic [CNT_W-1:0] mag_o
);
    drive_t act_q;

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= '0;
        else if (load_i)
            act_q <= next_i;
    end

    assign pwm_o = (cnt_i < act_q.mag);
    assign dir_o = act_q.dir;
    assign mag_o = act_q.mag;
endmodule

// File: rtl/motor_pwm_pair.sv
module motor_pwm_pair
    import mpp_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH*CMD_W-1:0] cmd_i,
    input  logic [NCH-1:0]     rev_i,
    output logic [NCH-1:0]     pwm_o,
    output logic [NCH-1:0]     dir_o,
    output logic               sync_o
);
    logic [CNT_W-1:0]     cnt_w;
    logic                 last_w;
    logic [NCH*CNT_W-1:0] mag_w;

    mpp_timebase u_tb (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt_w),
        .last_o (last_w),
        .sync_o (sync_o)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        drive_t nxt;

        mpp_sm_convert u_conv (
            .cmd_i (cmd_i[k*CMD_W +: CMD_W]),
            .rev_i (rev_i[k]),
            .drv_o (nxt)
        );

        mpp_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .load_i (last_w),
            .next_i (nxt),
            .cnt_i  (cnt_w),
            .pwm_o  (pwm_o[k]),
            .dir_o  (dir_o[k]),
            .mag_o  (mag_w[k*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/motor_pwm_pair_chk.sv
module motor_pwm_pair_chk
    import mpp_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CNT_W-1:0]     cnt,
    input logic [NCH*CNT_W-1:0] mag,
    input logic [NCH-1:0]       pwm,
    input logic [NCH-1:0]       dir,
    input logic                 sync
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1))); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> (cnt == '0)); // R1
    AST_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        sync |-> (cnt == '0)); // R1

    for (genvar k = 0; k < NCH; k++) begin : g_a
        AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
            (cnt != CNT_MAX) |=> $stable(dir[k])); // R8
        AST_MAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (cnt != CNT_MAX) |=> $stable(mag[k*CNT_W +: CNT_W])); // R8
        AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
            (mag[k*CNT_W +: CNT_W] == '0) |-> !pwm[k]); // R5
        AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
            ((cnt == '0) && (mag[k*CNT_W +: CNT_W] != '0)) |-> pwm[k]); // R2
        AST_FALL_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
            $fell(pwm[k]) |-> (cnt == mag[k*CNT_W +: CNT_W])); // R2
    end
endmodule

bind motor_pwm_pair motor_pwm_pair_chk #(.NCH(NCH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt_w),
    .mag  (mag_w),
    .pwm  (pwm_o),
    .dir  (dir_o),
    .sync (sync_o)
);

// File: tb/motor_pwm_pair_bench.sv
module motor_pwm_pair_bench;
    localparam int CLK_P = 10;
    localparam int PER   = 1024;
    localparam int NV    = 8;

    typedef struct packed {
        logic [10:0] c0;
        logic [10:0] c1;
        logic [1:0]  rv;
        logic [9:0]  m0;
        logic        d0;
        logic [9:0]  m1;
        logic        d1;
    } vec_t;

    // commands, reverse mask, expected magnitude/direction per channel
    localparam vec_t VECS [NV] = '{
        '{11'sd300,   -11'sd200,  2'b00, 10'd300,  1'b1, 10'd200,  1'b0},
        '{11'sd0,     11'sd1023,  2'b00, 10'd0,    1'b0, 10'd1023, 1'b1},
        '{-11'sd1024, 11'sd1,     2'b00, 10'd1023, 1'b0, 10'd1,    1'b1},
        '{11'sd0,     -11'sd1,    2'b11, 10'd0,    1'b1, 10'd1,    1'b1},
        '{11'sd512,   -11'sd512,  2'b01, 10'd512,  1'b0, 10'd512,  1'b0},
        '{-11'sd1023, 11'sd5,     2'b10, 10'd1023, 1'b0, 10'd5,    1'b0},
        '{11'sd1,     -11'sd1024, 2'b00, 10'd1,    1'b1, 10'd1023, 1'b0},
        '{11'sd0,     11'sd0,     2'b00, 10'd0,    1'b0, 10'd0,    1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] cmd = '0;
    logic [1:0]  rev = '0;
    logic [1:0]  pwm;
    logic [1:0]  dir;
    logic        sync;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    motor_pwm_pair u_motor_pwm_pair (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .rev_i  (rev),
        .pwm_o  (pwm),
        .dir_o  (dir),
        .sync_o (sync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance to the next period start; optionally require old directions held
    task automatic wait_sync(input logic pd0, input logic pd1, input bit hold);
        int bad = 0;
        @(negedge clk);
        while (!sync) begin
            if (hold && (dir[0] !== pd0 || dir[1] !== pd1)) bad++;
            @(negedge clk);
        end
        if (hold) check(bad == 0, "R8 direction held until wrap", bad, 0);
    endtask

    // count high cycles over one full period, starting at a sync cycle
    task automatic measure(output int h0, output int h1, input logic ed0, input logic ed1,
                           output int dbad);
        h0 = 0; h1 = 0; dbad = 0;
        for (int i = 0; i < PER; i++) begin
            if (pwm[0] === 1'b1) h0++;
            if (pwm[1] === 1'b1) h1++;
            if (dir[0] !== ed0 || dir[1] !== ed1) dbad++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n, h0, h1, db;
        logic pd0, pd1;

        // R10 reset state
        repeat (3) @(negedge clk);
        check(pwm == 2'b00, "R10 pwm low in reset", pwm, 0);
        check(dir == 2'b00, "R10 dir low in reset", dir, 0);
        check(sync == 1'b0, "R10 sync low in reset", sync, 0);
        rst = 1'b0;

        // R1 period length and sync width
        wait_sync(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(sync == 1'b0, "R1 sync one cycle wide", sync, 0);
        n = 1;
        while (!sync) begin
            @(negedge clk);
            n++;
        end
        check(n == PER, "R1 period length", n, PER);

        // vector table: R2 R3 R4 R5 R6 R7 R9
        pd0 = 1'b0; pd1 = 1'b0;
        for (int v = 0; v < NV; v++) begin
            cmd = {VECS[v].c1, VECS[v].c0};
            rev = VECS[v].rv;
            wait_sync(pd0, pd1, 1'b1);
            measure(h0, h1, VECS[v].d0, VECS[v].d1, db);
            check(h0 == int'(VECS[v].m0), $sformatf("R2 R3 R4 R5 R6 ch0 high count vec %0d", v), h0, VECS[v].m0);
            check(h1 == int'(VECS[v].m1), $sformatf("R2 R3 R4 R5 R6 R9 ch1 high count vec %0d", v), h1, VECS[v].m1);
            check(db == 0, $sformatf("R3 R4 R5 R7 R9 direction vec %0d", v), db, 0);
            pd0 = VECS[v].d0; pd1 = VECS[v].d1;
        end

        // R8 write in the last cycle of a period still lands at the wrap
        repeat (PER - 1) @(negedge clk);
        check(pwm == 2'b00 && dir == 2'b00, "R8 last cycle still old", {dir, pwm}, 0);
        cmd = {-11'sd100, 11'sd100};
        rev = 2'b00;
        @(negedge clk);
        check(sync == 1'b1, "R1 sync after late write", sync, 1);
        measure(h0, h1, 1'b1, 1'b0, db);
        check(h0 == 100 && h1 == 100, "R8 R9 late write applied", h0 + h1, 200);
        check(db == 0, "R8 late write direction", db, 0);

        // R10 reset mid-run
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pwm == 2'b00 && dir == 2'b00 && sync == 1'b0, "R10 mid-run reset", {sync, dir, pwm}, 0);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        check(pwm == 2'b00 && dir == 2'b00, "R10 first period after reset idle", {dir, pwm}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule